// File: doc/BRIEF.md
# Interrupt Priority Level Arbiter

This block decides, once per instruction boundary, whether the core must take an interrupt. Two kinds of request share a single level space. Bits of a software request word produce low levels, counted from the bottom of their window. Bits of an external line vector produce levels equal to their own index. The block resolves the winning level and builds a mask of every source that is asserted. It then compares the winning level with the current priority level of the core.

A check is armed ahead of time by the surrounding pipeline. Evaluation runs at the next instruction boundary where nothing blocks it, and the armed flag is dropped whatever the result. A taken interrupt produces a single-cycle trap request and loads the summary and identifier registers. A nonzero asynchronous trap request cannot be handled by this block, so it is reported through an error pulse and no trap is taken.

Top module: `irq_level_arbiter`

## Requirements
- R1: Software bits with index i in [SW_LO, SW_HI) (defaults 4 to 15) give level i − SW_LO + 1. The highest set bit in that window decides the software level.
- R2: External bits with index i in [EXT_LO, EXT_HI) (defaults 20 to 31) give level i, and the highest set bit decides. If any in-window external bit is set, the external level replaces the software level.
- R3: The summary mask has bit i set for every in-window software or external bit i that is set. Bits outside both windows (by default software bits 0 to 3 and external bits 16 to 19) add nothing to the level or to the summary.
- R4: An interrupt is taken only when the winning level is nonzero and strictly greater than `cur_level`.
- R5: Evaluation happens on a rising clock edge where `check_pending`, `insn_boundary` are 1 and `fault_pending`, `pc_priv`, `replay_pending` are all 0. On any other edge the outputs `trap_req`, `async_err`, `isr_q` and `intid_q` do not react to the source inputs.
- R6: When an interrupt is taken, `trap_req` is 1 for exactly the one cycle after the evaluating edge. At that same edge `isr_q` takes the summary and `intid_q` takes the level. Both registers then hold until the next taken interrupt.
- R7: `check_pending` is set by `arm_check`. It is cleared by an evaluation whatever the outcome, and an `arm_check` in the evaluating cycle is dropped.
- R8: If `async_req` is nonzero at an evaluation, `async_err` is 1 for the following cycle, no trap is raised, and `isr_q`/`intid_q` hold.
- R9: With `rst_n` low at a clock edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_check | input | 1 | Requests an interrupt check at a later boundary |
| insn_boundary | input | 1 | Current cycle is an instruction boundary |
| fault_pending | input | 1 | A fault is outstanding; blocks evaluation |
| pc_priv | input | 1 | PC is in privileged firmware mode; blocks evaluation |
| replay_pending | input | 1 | Fetch replay after an instruction-cache miss is due; blocks evaluation |
| sw_req | input | DATA_W | Software interrupt request word |
| ext_lines | input | DATA_W | External interrupt lines |
| cur_level | input | LVL_W | Current interrupt priority level |
| async_req | input | DATA_W | Asynchronous trap request word |
| trap_req | output | 1 | One-cycle interrupt trap request |
| isr_q | output | DATA_W | Interrupt summary register |
| intid_q | output | LVL_W | Interrupt identifier (level) register |
| async_err | output | 1 | One-cycle unsupported asynchronous trap flag |
| check_pending | output | 1 | An interrupt check is armed |

## Verification
Every result is registered once. Trap, error, summary, identifier and the pending flag all reflect the inputs applied before a rising edge and are due in the cycle after it. The driver applies inputs just after a falling edge and pushes the outcome it predicts for the coming rising edge. The monitor pops that item at the next falling edge, so each comparison falls exactly one edge after its stimulus. Blocked or ignored stimuli are checked the same way: the predicted item says the registers hold and the pending flag stays set.

// File: rtl/irq_arb_pkg.sv
// Package: shared outcome encoding for the interrupt level arbiter.
// Assumes nothing beyond standard SystemVerilog.
package irq_arb_pkg;
    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_NONE  = 2'd1,
        OUT_TAKE  = 2'd2,
        OUT_ASYNC = 2'd3
    } arb_outcome_e;
endpackage

// File: rtl/irq_window_scan.sv
// Scans one bit window of a request word. Each set bit i in [LO, HI) gives
// level i - LO + BASE, and the highest set bit wins. Also returns the in-window
// bits as a mask. Assumes 0 <= LO < HI <= DATA_W.
module irq_window_scan #(
    parameter int DATA_W = 64,
    parameter int LVL_W  = 7,
    parameter int LO     = 4,
    parameter int HI     = 16,
    parameter int BASE   = 1
) (
    input  logic [DATA_W-1:0] bits_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              any_o
);
    logic [DATA_W-1:0] in_window;

    // static window mask, one bit per position
    for (genvar g = 0; g < DATA_W; g++) begin : g_win
        assign in_window[g] = (g >= LO) && (g < HI);
    end

    assign mask_o = bits_i & in_window;
    assign any_o  = |mask_o;

    // ascending scan: a later set bit replaces an earlier level
    always_comb begin
        level_o = '0;
        for (int i = LO; i < HI; i++) begin
            if (bits_i[i]) level_o = LVL_W'(i - LO + BASE);
        end
    end
endmodule

// File: rtl/irq_take_decide.sv
// Merges software and external scan results and decides the outcome of one
// evaluation. External sources override software sources. Any nonzero
// asynchronous request turns the outcome into an error.
module irq_take_decide
    import irq_arb_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LVL_W  = 7
) (
    input  logic              eval_i,
    input  logic [DATA_W-1:0] sw_mask_i,
    input  logic [LVL_W-1:0]  sw_level_i,
    input  logic [DATA_W-1:0] ext_mask_i,
    input  logic [LVL_W-1:0]  ext_level_i,
    input  logic              ext_any_i,
    input  logic [LVL_W-1:0]  cur_level_i,
    input  logic [DATA_W-1:0] async_i,
    output logic [DATA_W-1:0] summary_o,
    output logic [LVL_W-1:0]  level_o,
    output arb_outcome_e      outcome_o
);
    // merged level and summary
    always_comb begin
        summary_o = sw_mask_i | ext_mask_i;
        level_o   = ext_any_i ? ext_level_i : sw_level_i;
    end

    // outcome selection for this cycle
    always_comb begin
        if (!eval_i)                                        outcome_o = OUT_IDLE;
        else if (|async_i)                                  outcome_o = OUT_ASYNC;
        else if ((level_o != '0) && (level_o > cur_level_i)) outcome_o = OUT_TAKE;
        else                                                outcome_o = OUT_NONE;
    end
endmodule

// File: rtl/irq_level_arbiter.sv
// Top: interrupt priority level arbiter. Holds the armed-check flag, gates
// evaluation with the boundary and blocking conditions, and registers the
// trap pulse, error pulse, summary and identifier.
// Assumes the two windows lie inside DATA_W and that the levels fit in LVL_W.
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SW_LO  = 4,
    parameter int SW_HI  = 16,
    parameter int EXT_LO = 20,
    parameter int EXT_HI = 32,
    localparam int LVL_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_check,
    input  logic              insn_boundary,
    input  logic              fault_pending,
    input  logic              pc_priv,
    input  logic              replay_pending,
    input  logic [DATA_W-1:0] sw_req,
    input  logic [DATA_W-1:0] ext_lines,
    input  logic [LVL_W-1:0]  cur_level,
    input  logic [DATA_W-1:0] async_req,
    output logic              trap_req,
    output logic [DATA_W-1:0] isr_q,
    output logic [LVL_W-1:0]  intid_q,
    output logic              async_err,
    output logic              check_pending
);
    logic [DATA_W-1:0] sw_mask, ext_mask, summary;
    logic [LVL_W-1:0]  sw_level, ext_level, win_level;
    logic              sw_any, ext_any, eval_now;
    arb_outcome_e      outcome;

    // evaluation gate: armed, at a boundary and not blocked
    assign eval_now = check_pending && insn_boundary && !fault_pending
                      && !pc_priv && !replay_pending;

    irq_window_scan #(
        .DATA_W(DATA_W), .LVL_W(LVL_W), .LO(SW_LO), .HI(SW_HI), .BASE(1)
    ) u_sw_scan (
        .bits_i(sw_req), .mask_o(sw_mask), .level_o(sw_level), .any_o(sw_any)
    );

    irq_window_scan #(
        .DATA_W(DATA_W), .LVL_W(LVL_W), .LO(EXT_LO), .HI(EXT_HI), .BASE(EXT_LO)
    ) u_ext_scan (
        .bits_i(ext_lines), .mask_o(ext_mask), .level_o(ext_level), .any_o(ext_any)
    );

    irq_take_decide #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_decide (
        .eval_i(eval_now),
        .sw_mask_i(sw_mask), .sw_level_i(sw_level),
        .ext_mask_i(ext_mask), .ext_level_i(ext_level), .ext_any_i(ext_any),
        .cur_level_i(cur_level), .async_i(async_req),
        .summary_o(summary), .level_o(win_level), .outcome_o(outcome)
    );

    // armed flag: set by request, cleared by evaluation (evaluation wins)
    always_ff @(posedge clk) begin
        if (!rst_n)        check_pending <= 1'b0;
        else if (eval_now) check_pending <= 1'b0;
        else if (arm_check) check_pending <= 1'b1;
    end

    // one-cycle pulses for trap and unsupported asynchronous request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_req  <= 1'b0;
            async_err <= 1'b0;
        end else begin
            trap_req  <= (outcome == OUT_TAKE);
            async_err <= (outcome == OUT_ASYNC);
        end
    end

    // summary and identifier registers, written only on a taken interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q   <= '0;
            intid_q <= '0;
        end else if (outcome == OUT_TAKE) begin
            isr_q   <= summary;
            intid_q <= win_level;
        end
    end

    logic unused_any;
    assign unused_any = sw_any;
endmodule

// File: rtl/irq_level_arbiter_chk.sv
// Checker for the interrupt level arbiter, attached by bind. Relates the
// registered outputs to the inputs of the evaluating cycle.
module irq_level_arbiter_chk #(
    parameter int DATA_W = 64,
    parameter int LVL_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_boundary,
    input logic              fault_pending,
    input logic [LVL_W-1:0]  cur_level,
    input logic              trap_req,
    input logic [DATA_W-1:0] isr_q,
    input logic [LVL_W-1:0]  intid_q,
    input logic              async_err,
    input logic              check_pending
);
    // R4
    trap_level_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (intid_q != '0) && (intid_q > $past(cur_level)));
    // R6
    trap_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);
    // R6
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> $stable(isr_q) && $stable(intid_q));
    // R8
    err_excludes_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req && async_err));
    // R7
    pending_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req || async_err) |-> !check_pending);
    // R5
    fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (check_pending && fault_pending) |=> check_pending && !trap_req && !async_err);
    // R5
    no_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (check_pending && !insn_boundary) |=> check_pending);
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary),
    .fault_pending(fault_pending), .cur_level(cur_level),
    .trap_req(trap_req), .isr_q(isr_q), .intid_q(intid_q),
    .async_err(async_err), .check_pending(check_pending)
);

// File: tb/irq_level_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_level_arbiter_tb_top;
    localparam int DW = 64, SWL = 4, SWH = 16, EXL = 20, EXH = 32;
    localparam int LW = $clog2(DW + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic arm_check = 0, insn_boundary = 0, fault_pending = 0, pc_priv = 0, replay_pending = 0;
    logic [DW-1:0] sw_req = '0, ext_lines = '0, async_req = '0;
    logic [LW-1:0] cur_level = '0;
    logic trap_req, async_err, check_pending;
    logic [DW-1:0] isr_q;
    logic [LW-1:0] intid_q;

    always #2 clk = ~clk;

    irq_level_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .arm_check(arm_check), .insn_boundary(insn_boundary),
        .fault_pending(fault_pending), .pc_priv(pc_priv), .replay_pending(replay_pending),
        .sw_req(sw_req), .ext_lines(ext_lines), .cur_level(cur_level), .async_req(async_req),
        .trap_req(trap_req), .isr_q(isr_q), .intid_q(intid_q),
        .async_err(async_err), .check_pending(check_pending)
    );

    typedef struct {
        logic          trap, err, pend;
        logic [DW-1:0] isr;
        logic [LW-1:0] id;
        string         tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;
    bit done = 0;
    logic          m_pend = 0;
    logic [DW-1:0] m_isr = '0;
    logic [LW-1:0] m_id = '0;

    task automatic compare(exp_t e);
        checks++;
        if (trap_req !== e.trap || async_err !== e.err || check_pending !== e.pend ||
            isr_q !== e.isr || intid_q !== e.id) begin
            errors++;
            $display("FAIL %s: trap=%0b/%0b err=%0b/%0b pend=%0b/%0b isr=%h/%h id=%0d/%0d",
                     e.tag, trap_req, e.trap, async_err, e.err, check_pending, e.pend,
                     isr_q, e.isr, intid_q, e.id);
        end
    endtask

    // driver: apply one cycle of stimulus and predict the result of the next edge
    task automatic drive(input logic arm, bnd, flt, prv, rpl,
                         input logic [DW-1:0] sw, ext, asy,
                         input int cur, input string tag);
        exp_t e;
        int lvl;
        logic [DW-1:0] sum;
        logic ev;
        @(negedge clk); #1;
        arm_check = arm; insn_boundary = bnd; fault_pending = flt; pc_priv = prv;
        replay_pending = rpl; sw_req = sw; ext_lines = ext; async_req = asy;
        cur_level = LW'(cur);
        lvl = 0; sum = '0;
        for (int i = SWL; i < SWH; i++) if (sw[i]) begin lvl = i - SWL + 1; sum[i] = 1'b1; end
        for (int i = EXL; i < EXH; i++) if (ext[i]) begin lvl = i; sum[i] = 1'b1; end
        ev = m_pend && bnd && !flt && !prv && !rpl;
        e.err  = ev && (asy != '0);
        e.trap = ev && !e.err && lvl != 0 && lvl > cur;
        if (e.trap) begin m_isr = sum; m_id = LW'(lvl); end
        m_pend = ev ? 1'b0 : (m_pend | arm);
        e.pend = m_pend; e.isr = m_isr; e.id = m_id; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare one predicted item per falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    function automatic logic [DW-1:0] b(input int i);
        return DW'(1) << i;
    endfunction

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        r.trap = 0; r.err = 0; r.pend = 0; r.isr = '0; r.id = '0; r.tag = "R9 reset";
        compare(r);
        rst_n = 1'b1;
        // R7 arm, then R1 software only: bits 5 and 9 -> level 6
        drive(1, 0, 0, 0, 0, '0, '0, '0, 0, "R7 arm");
        drive(0, 1, 0, 0, 0, b(5) | b(9), '0, '0, 0, "R1 sw level");
        drive(0, 0, 0, 0, 0, '0, '0, '0, 0, "R6 single pulse");
        // R2 external overrides software; summary covers both
        drive(1, 0, 0, 0, 0, '0, '0, '0, 0, "R7 arm");
        drive(0, 1, 0, 0, 0, b(15), b(21) | b(25), '0, 3, "R2 ext override");
        // R4 equal level not taken, pending still cleared, regs hold
        drive(1, 0, 0, 0, 0, '0, '0, '0, 0, "R7 arm");
        drive(0, 1, 0, 0, 0, '0, b(25), '0, 25, "R4 equal level");
        // R4 level below cur
        drive(1, 0, 0, 0, 0, '0, '0, '0, 0, "R7 arm");
        drive(0, 1, 0, 0, 0, b(7), '0, '0, 10, "R4 lower level");
        // R5 blockers keep the check armed
        drive(1, 0, 0, 0, 0, '0, '0, '0, 0, "R7 arm");
        drive(0, 1, 1, 0, 0, '0, b(30), '0, 0, "R5 fault blocks");
        drive(0, 1, 0, 1, 0, '0, b(30), '0, 0, "R5 priv blocks");
        drive(0, 1, 0, 0, 1, '0, b(30), '0, 0, "R5 replay blocks");
        drive(0, 0, 0, 0, 0, '0, b(30), '0, 0, "R5 no boundary");
        // R3 out-of-window bits ignored -> level 0, no trap
        drive(0, 1, 0, 0, 0, b(0) | b(3), b(16) | b(19), '0, 0, "R3 out of window");
        // R8 asynchronous request -> error, no trap
        drive(1, 0, 0, 0, 0, '0, '0, '0, 0, "R7 arm");
        drive(0, 1, 0, 0, 0, '0, b(31), b(2), 0, "R8 async error");
        // R7 arm during evaluation is dropped
        drive(1, 0, 0, 0, 0, '0, '0, '0, 0, "R7 arm");
        drive(1, 1, 0, 0, 0, b(15), '0, '0, 0, "R7 arm during eval");
        drive(0, 1, 0, 0, 0, '0, b(31), '0, 0, "R7 no re-arm");
        // R1 highest software bit wins, and R3 software summary only
        drive(1, 0, 0, 0, 0, '0, '0, '0, 0, "R7 arm");
        drive(0, 1, 0, 0, 0, b(4) | b(6) | b(2), '0, '0, 0, "R1 highest sw bit");
        drive(0, 0, 0, 0, 0, '0, '0, '0, 0, "R6 hold");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule